// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block is the register-side front end of a fixed-function compute core. A host on an AXI4-Lite bus writes the core's scalar arguments into word-aligned registers and sets a start bit. The block then holds a start level towards the core. The core reports completion with single-cycle done and ready pulses, and reports a live idle level. A control word at offset 0x00 gathers these handshake bits with a restart-forever mode. Argument registers begin at 0x10: an 8-bit input `a`, an 8-bit input `b` with a valid flag that clears itself, an 8-bit input `ci`, and an 8-bit read-only result `co` with a valid flag that a read clears.

The write channel runs a four-state machine. `WR_IDLE` accepts address and data. If both arrive in the same cycle it writes and moves to `WR_RESP`. If only the address arrives it moves to `WR_GOT_ADDR`, and if only the data arrives it moves to `WR_GOT_DATA`. `WR_GOT_ADDR` moves to `WR_RESP` when the data arrives, and `WR_GOT_DATA` moves to `WR_RESP` when the address arrives. `WR_RESP` presents the response and returns to `WR_IDLE` when the host accepts it. The read channel has two states. `RD_IDLE` captures the selected word when the address handshake happens and moves to `RD_RESP`. `RD_RESP` holds the data and returns to `RD_IDLE` when the host accepts it. Offsets 0x04 to 0x0C belong to an interrupt unit outside this block and read here as zero.

Top module: `accel_ctrl_slave`

## Requirements
- R1: A read of offset 0x00 returns start in bit 0, done in bit 1, the core's idle input in bit 2, the core's ready input in bit 3 and the restart mode in bit 7. Every other bit reads 0.
- R2: A write to 0x00 with bit 0 set sets the start bit, and `core_start` follows from the next cycle. A write with bit 0 clear leaves the start bit unchanged. Bit 7 of every write to 0x00 is stored as the restart mode.
- R3: When `core_ready` is high while start is set, start is clear in the next cycle. The exception is a cycle in which start is also being set, by a write or by a restart; setting wins.
- R4: When `core_done` is high while the restart mode is 1, start is set in the next cycle.
- R5: A `core_done` pulse sets the done bit. An accepted read of 0x00 returns the done bit and then clears it. If a done pulse arrives in the same cycle as that read, the bit stays set.
- R6: Argument `a` at 0x10, `b` at 0x18 and `ci` at 0x20 store bits 7:0 of a write, drive `arg_a`, `arg_b` and `arg_ci`, read back zero-extended, and reset to 0.
- R7: Bit 0 of 0x1C is the valid flag of `b`. A write stores bit 0 of the data into it, and a `core_ready` pulse clears it. A write in the same cycle as the pulse wins. The flag drives `arg_b_vld`.
- R8: A `core_co_vld` pulse latches `core_co` into 0x28 and sets bit 0 of 0x2C. A read of 0x2C clears that flag. Writes to 0x28 and 0x2C change nothing.
- R9: Offsets 0x04, 0x08, 0x0C, 0x14, 0x24 and 0x30 to 0x3C read as 0, and writes to them change no register.
- R10: Write address and write data are accepted in either order or together, with one write and one read in flight at a time. Every response is OKAY (00).
- R11: A write changes a register only when `s_wstrb[0]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 6 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 6 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| core_start | output | 1 | Start level to the core |
| core_done | input | 1 | Core completion pulse |
| core_idle | input | 1 | Core idle level |
| core_ready | input | 1 | Core accepted-inputs pulse |
| arg_a | output | 8 | Argument a |
| arg_b | output | 8 | Argument b |
| arg_b_vld | output | 1 | Valid flag of argument b |
| arg_ci | output | 8 | Input half of the c pair |
| core_co | input | 8 | Result from the core |
| core_co_vld | input | 1 | Result valid pulse |

## Verification
The assertions assume that the host keeps each valid high until its handshake completes. They also assume that `core_done`, `core_ready` and `core_co_vld` are single-cycle pulses whose effect shows one cycle later. The stimulus respects both assumptions. Bus tasks hold each valid until the matching ready has been seen. Core events are driven as one-cycle pulses between clock edges. The response readies stay high, so every response is taken in the cycle it appears. Cases where a set and a clear compete for the same bit are driven on purpose: a ready and a done pulse arrive together while the restart mode is on.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic [1:0] {
        WR_IDLE,
        WR_GOT_ADDR,
        WR_GOT_DATA,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

    // byte offsets of the mapped words
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_A     = 8'h10;
    localparam logic [7:0] OFS_B     = 8'h18;
    localparam logic [7:0] OFS_B_VLD = 8'h1C;
    localparam logic [7:0] OFS_CI    = 8'h20;
    localparam logic [7:0] OFS_CO    = 8'h28;
    localparam logic [7:0] OFS_CO_VLD= 8'h2C;

    // bit positions inside the control word
    localparam int CB_START = 0;
    localparam int CB_DONE  = 1;
    localparam int CB_IDLE  = 2;
    localparam int CB_READY = 3;
    localparam int CB_AUTO  = 7;

    localparam logic [1:0] RESP_OKAY = 2'b00;

endpackage

// File: rtl/acs_wr_fsm.sv
module acs_wr_fsm
    import acs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W/8-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_be0
);

    localparam int STRB_W = DATA_W / 8;

    wr_state_e         state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              be0_q;
    logic              aw_hs, w_hs;
    logic [STRB_W-1:0] unused_strb;

    assign unused_strb = wstrb;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // held halves of a write that arrived in pieces
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be0_q  <= 1'b0;
        end else begin
            if (aw_hs) addr_q <= awaddr;
            if (w_hs) begin
                data_q <= wdata;
                be0_q  <= wstrb[0];
            end
        end
    end

    // outputs and next state
    always_comb begin
        awready = (state_q == WR_IDLE) || (state_q == WR_GOT_DATA);
        wready  = (state_q == WR_IDLE) || (state_q == WR_GOT_ADDR);
        aw_hs   = awvalid && awready;
        w_hs    = wvalid && wready;
        bvalid  = (state_q == WR_RESP);
        bresp   = RESP_OKAY;
        wr_fire = 1'b0;
        wr_addr = (state_q == WR_GOT_ADDR) ? addr_q : awaddr;
        wr_data = (state_q == WR_GOT_DATA) ? data_q : wdata;
        wr_be0  = (state_q == WR_GOT_DATA) ? be0_q  : wstrb[0];
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_hs && w_hs) begin
                    wr_fire = 1'b1;
                    state_d = WR_RESP;
                end else if (aw_hs) begin
                    state_d = WR_GOT_ADDR;
                end else if (w_hs) begin
                    state_d = WR_GOT_DATA;
                end
            end
            WR_GOT_ADDR: begin
                if (w_hs) begin
                    wr_fire = 1'b1;
                    state_d = WR_RESP;
                end
            end
            WR_GOT_DATA: begin
                if (aw_hs) begin
                    wr_fire = 1'b1;
                    state_d = WR_RESP;
                end
            end
            WR_RESP: begin
                if (bready) state_d = WR_IDLE;
            end
            default: state_d = WR_IDLE;
        endcase
    end

    // R10
    wr_resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);

    // R10
    wr_one_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> (!wr_fire && bvalid));

    // R10
    wr_no_accept_in_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> (!awready && !wready));

endmodule

// File: rtl/acs_rd_fsm.sv
module acs_rd_fsm
    import acs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rd_fire,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_word
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // word captured when the address is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (rd_fire) begin
            data_q <= rd_word;
        end
    end

    // outputs and next state
    always_comb begin
        arready = (state_q == RD_IDLE);
        rvalid  = (state_q == RD_RESP);
        rdata   = data_q;
        rresp   = RESP_OKAY;
        rd_addr = araddr;
        rd_fire = 1'b0;
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: begin
                if (arvalid) begin
                    rd_fire = 1'b1;
                    state_d = RD_RESP;
                end
            end
            RD_RESP: begin
                if (rready) state_d = RD_IDLE;
            end
            default: state_d = RD_IDLE;
        endcase
    end

    // R10
    rd_resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> (rvalid && !arready));

endmodule

// File: rtl/acs_regs.sv
module acs_regs
    import acs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int ARG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_be0,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    input  logic [ARG_W-1:0]  core_co,
    input  logic              core_co_vld,
    output logic              core_start,
    output logic [ARG_W-1:0]  arg_a,
    output logic [ARG_W-1:0]  arg_b,
    output logic              arg_b_vld,
    output logic [ARG_W-1:0]  arg_ci
);

    localparam int HI_W = DATA_W - ARG_W;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        logic [ADDR_W-1:0] o;
        o = ADDR_W'(ofs);
        return a[ADDR_W-1:2] == o[ADDR_W-1:2];
    endfunction

    logic             start_q, auto_q, done_q, bvld_q, covld_q;
    logic [ARG_W-1:0] a_q, b_q, ci_q, co_q;
    logic             wr_en, wr_ctrl, set_start, clr_start;
    logic             rd_ctrl, rd_covld;
    logic [HI_W-1:0]  unused_hi;

    assign unused_hi = wr_data[DATA_W-1:ARG_W];

    always_comb begin
        wr_en     = wr_fire && wr_be0;
        wr_ctrl   = wr_en && hit(wr_addr, OFS_CTRL);
        set_start = (wr_ctrl && wr_data[CB_START]) || (core_done && auto_q);
        clr_start = core_ready && start_q;
        rd_ctrl   = rd_fire && hit(rd_addr, OFS_CTRL);
        rd_covld  = rd_fire && hit(rd_addr, OFS_CO_VLD);
    end

    // handshake bits of the control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            auto_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (set_start)      start_q <= 1'b1;
            else if (clr_start) start_q <= 1'b0;
            if (wr_ctrl)        auto_q  <= wr_data[CB_AUTO];
            if (core_done)      done_q  <= 1'b1;
            else if (rd_ctrl)   done_q  <= 1'b0;
        end
    end

    // argument registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            ci_q    <= '0;
            bvld_q  <= 1'b0;
            co_q    <= '0;
            covld_q <= 1'b0;
        end else begin
            if (wr_en && hit(wr_addr, OFS_A))  a_q  <= wr_data[ARG_W-1:0];
            if (wr_en && hit(wr_addr, OFS_B))  b_q  <= wr_data[ARG_W-1:0];
            if (wr_en && hit(wr_addr, OFS_CI)) ci_q <= wr_data[ARG_W-1:0];
            if (wr_en && hit(wr_addr, OFS_B_VLD)) bvld_q <= wr_data[0];
            else if (core_ready)                  bvld_q <= 1'b0;
            if (core_co_vld) co_q <= core_co;
            if (core_co_vld)   covld_q <= 1'b1;
            else if (rd_covld) covld_q <= 1'b0;
        end
    end

    // read mux
    always_comb begin
        rd_word = '0;
        if (hit(rd_addr, OFS_CTRL)) begin
            rd_word[CB_START] = start_q;
            rd_word[CB_DONE]  = done_q;
            rd_word[CB_IDLE]  = core_idle;
            rd_word[CB_READY] = core_ready;
            rd_word[CB_AUTO]  = auto_q;
        end else if (hit(rd_addr, OFS_A)) begin
            rd_word = DATA_W'(a_q);
        end else if (hit(rd_addr, OFS_B)) begin
            rd_word = DATA_W'(b_q);
        end else if (hit(rd_addr, OFS_B_VLD)) begin
            rd_word[0] = bvld_q;
        end else if (hit(rd_addr, OFS_CI)) begin
            rd_word = DATA_W'(ci_q);
        end else if (hit(rd_addr, OFS_CO)) begin
            rd_word = DATA_W'(co_q);
        end else if (hit(rd_addr, OFS_CO_VLD)) begin
            rd_word[0] = covld_q;
        end
    end

    assign core_start = start_q;
    assign arg_a      = a_q;
    assign arg_b      = b_q;
    assign arg_b_vld  = bvld_q;
    assign arg_ci     = ci_q;

    // R3
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ready && core_start && !core_done && !wr_ctrl) |=> !core_start);

    // R4
    auto_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && auto_q) |=> core_start);

    // R5
    done_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> done_q);

    // R7
    bvld_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ready && !wr_en) |=> !arg_b_vld);

    // R8
    co_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_co_vld |=> (covld_q && co_q == $past(core_co)));

endmodule

// File: rtl/accel_ctrl_slave.sv
module accel_ctrl_slave
    import acs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int ARG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [DATA_W/8-1:0] s_wstrb,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              core_start,
    input  logic              core_done,
    input  logic              core_idle,
    input  logic              core_ready,
    output logic [ARG_W-1:0]  arg_a,
    output logic [ARG_W-1:0]  arg_b,
    output logic              arg_b_vld,
    output logic [ARG_W-1:0]  arg_ci,
    input  logic [ARG_W-1:0]  core_co,
    input  logic              core_co_vld
);

    logic              wr_fire, wr_be0, rd_fire;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_word;

    acs_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .awaddr  (s_awaddr),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .bresp   (s_bresp),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be0  (wr_be0)
    );

    acs_rd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .araddr  (s_araddr),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rd_fire (rd_fire),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    acs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARG_W(ARG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .wr_be0      (wr_be0),
        .rd_fire     (rd_fire),
        .rd_addr     (rd_addr),
        .rd_word     (rd_word),
        .core_done   (core_done),
        .core_idle   (core_idle),
        .core_ready  (core_ready),
        .core_co     (core_co),
        .core_co_vld (core_co_vld),
        .core_start  (core_start),
        .arg_a       (arg_a),
        .arg_b       (arg_b),
        .arg_b_vld   (arg_b_vld),
        .arg_ci      (arg_ci)
    );

endmodule

// File: tb/sim_accel_ctrl_slave.sv
`timescale 1ns/1ps
module sim_accel_ctrl_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_awvalid = 0, s_wvalid = 0, s_arvalid = 0;
    logic        s_bready = 1, s_rready = 1;
    logic [5:0]  s_awaddr = '0, s_araddr = '0;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
    logic [1:0]  s_bresp, s_rresp;
    logic [31:0] s_rdata;
    logic        core_start, core_done = 0, core_idle = 1, core_ready = 0, core_co_vld = 0;
    logic [7:0]  core_co = '0, arg_a, arg_b, arg_ci;
    logic        arg_b_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    accel_ctrl_slave u0 (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
        .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
        .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
        .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
        .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
        .core_start(core_start), .core_done(core_done), .core_idle(core_idle),
        .core_ready(core_ready), .arg_a(arg_a), .arg_b(arg_b), .arg_b_vld(arg_b_vld),
        .arg_ci(arg_ci), .core_co(core_co), .core_co_vld(core_co_vld)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] a);
        case (a[5:2])
            4'd0:             return "R1/R5 ctrl";
            4'd4, 4'd6, 4'd8: return "R6 arg";
            4'd7:             return "R7 bvld";
            4'd10, 4'd11:     return "R8 result";
            default:          return "R9 reserved";
        endcase
    endfunction

    // ---------------- behavioural reference ----------------
    logic        m_start, m_auto, m_done, m_bv, m_cov;
    logic [7:0]  m_a, m_b, m_ci, m_co;
    logic        m_awp, m_wp;
    logic [5:0]  m_awaddr;
    logic [31:0] m_wdata;
    logic [3:0]  m_wstrb;
    logic [31:0] exp_q[$];
    logic [5:0]  exp_a_q[$];

    function automatic logic [31:0] expect_word(input logic [5:0] a);
        logic [31:0] w;
        w = 32'd0;
        case (a[5:2])
            4'd0:  begin w[0]=m_start; w[1]=m_done; w[2]=core_idle; w[3]=core_ready; w[7]=m_auto; end
            4'd4:  w[7:0] = m_a;
            4'd6:  w[7:0] = m_b;
            4'd7:  w[0]   = m_bv;
            4'd8:  w[7:0] = m_ci;
            4'd10: w[7:0] = m_co;
            4'd11: w[0]   = m_cov;
            default: w = 32'd0;
        endcase
        return w;
    endfunction

    always @(posedge clk) begin
        logic        haw, hw, fire, we, ar;
        logic [5:0]  fa;
        logic [31:0] fd;
        logic [3:0]  fs;
        logic        n_start, n_done, n_bv, n_cov;
        if (!rst_n) begin
            m_start = 0; m_auto = 0; m_done = 0; m_bv = 0; m_cov = 0;
            m_a = 0; m_b = 0; m_ci = 0; m_co = 0;
            m_awp = 0; m_wp = 0; m_awaddr = 0; m_wdata = 0; m_wstrb = 0;
            exp_q.delete(); exp_a_q.delete();
        end else begin
            haw = m_awp; fa = m_awaddr;
            if (s_awvalid && s_awready) begin haw = 1; fa = s_awaddr; end
            hw = m_wp; fd = m_wdata; fs = m_wstrb;
            if (s_wvalid && s_wready) begin hw = 1; fd = s_wdata; fs = s_wstrb; end
            fire = haw && hw;
            if (fire) begin
                m_awp = 0; m_wp = 0;
            end else begin
                m_awp = haw; m_awaddr = fa; m_wp = hw; m_wdata = fd; m_wstrb = fs;
            end
            we = fire && fs[0];
            ar = s_arvalid && s_arready;
            if (ar) begin
                exp_q.push_back(expect_word(s_araddr));
                exp_a_q.push_back(s_araddr);
            end
            n_start = m_start;
            if (core_ready && m_start) n_start = 0;
            if ((we && fa[5:2] == 4'd0 && fd[0]) || (core_done && m_auto)) n_start = 1;
            n_done = m_done;
            if (ar && s_araddr[5:2] == 4'd0) n_done = 0;
            if (core_done) n_done = 1;
            n_bv = m_bv;
            if (core_ready) n_bv = 0;
            if (we && fa[5:2] == 4'd7) n_bv = fd[0];
            n_cov = m_cov;
            if (ar && s_araddr[5:2] == 4'd11) n_cov = 0;
            if (core_co_vld) n_cov = 1;
            if (we && fa[5:2] == 4'd0) m_auto = fd[7];
            if (we && fa[5:2] == 4'd4) m_a  = fd[7:0];
            if (we && fa[5:2] == 4'd6) m_b  = fd[7:0];
            if (we && fa[5:2] == 4'd8) m_ci = fd[7:0];
            if (core_co_vld) m_co = core_co;
            m_start = n_start; m_done = n_done; m_bv = n_bv; m_cov = n_cov;
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R2/R3/R4 core_start", {31'd0, core_start}, {31'd0, m_start});
            check("R6 arg_a",  {24'd0, arg_a},  {24'd0, m_a});
            check("R6 arg_b",  {24'd0, arg_b},  {24'd0, m_b});
            check("R6 arg_ci", {24'd0, arg_ci}, {24'd0, m_ci});
            check("R7 arg_b_vld", {31'd0, arg_b_vld}, {31'd0, m_bv});
            if (s_bvalid) check("R10 bresp", {30'd0, s_bresp}, 32'd0);
            if (s_rvalid && s_rready) begin
                check("R10 rresp", {30'd0, s_rresp}, 32'd0);
                if (exp_q.size() == 0) begin
                    check("R10 unexpected read", 32'd1, 32'd0);
                end else begin
                    check(tag_of(exp_a_q.pop_front()), s_rdata, exp_q.pop_front());
                end
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic axi_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] st, input int order);
        bit aw_done, w_done, aw_acc, w_acc;
        aw_done = 0; w_done = 0;
        @(negedge clk);
        if (order != 2) begin s_awvalid = 1; s_awaddr = a; end
        if (order != 1) begin s_wvalid = 1; s_wdata = d; s_wstrb = st; end
        while (!(aw_done && w_done)) begin
            aw_acc = s_awvalid && s_awready;
            w_acc  = s_wvalid && s_wready;
            @(negedge clk);
            if (aw_acc) begin s_awvalid = 0; aw_done = 1; end
            if (w_acc)  begin s_wvalid = 0;  w_done = 1;  end
            if (aw_done && !w_done && !s_wvalid) begin s_wvalid = 1; s_wdata = d; s_wstrb = st; end
            if (w_done && !aw_done && !s_awvalid) begin s_awvalid = 1; s_awaddr = a; end
        end
        while (!s_bvalid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic axi_rd(input logic [5:0] a);
        @(negedge clk);
        s_arvalid = 1; s_araddr = a;
        while (!s_arready) @(negedge clk);
        @(negedge clk);
        s_arvalid = 0;
        while (!s_rvalid) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic core_pulse(input logic d, input logic r, input logic cv, input logic [7:0] co);
        @(negedge clk);
        core_done = d; core_ready = r; core_co_vld = cv; core_co = co;
        @(negedge clk);
        core_done = 0; core_ready = 0; core_co_vld = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state, R6 and R2
        check("R6 reset arg_a", {24'd0, arg_a}, 32'd0);
        check("R2 reset core_start", {31'd0, core_start}, 32'd0);
        axi_rd(6'h00);                       // R1 idle visible
        // R6 argument writes, R10 orders
        axi_wr(6'h10, 32'hFFFF_FF5A, 4'hF, 0);
        axi_rd(6'h10);
        axi_wr(6'h18, 32'h0000_00C3, 4'h1, 1);
        axi_wr(6'h1C, 32'h1, 4'h1, 2);
        axi_rd(6'h18);
        axi_rd(6'h1C);
        axi_wr(6'h20, 32'h77, 4'hF, 2);
        axi_rd(6'h20);
        // R9 reserved / unmapped
        axi_wr(6'h14, 32'hFFFF_FFFF, 4'hF, 0);
        axi_wr(6'h3C, 32'hFFFF_FFFF, 4'hF, 1);
        axi_rd(6'h14);
        axi_rd(6'h04);
        axi_rd(6'h3C);
        // R11 strobe gating
        axi_wr(6'h10, 32'h11, 4'h0, 0);
        check("R11 arg_a unchanged", {24'd0, arg_a}, 32'h5A);
        // R2 start, R3 clear, R7 self clear
        axi_wr(6'h00, 32'h1, 4'h1, 0);
        core_idle = 0;
        axi_rd(6'h00);
        core_pulse(0, 1, 0, 8'h00);
        check("R3 start cleared by ready", {31'd0, core_start}, 32'd0);
        check("R7 b valid cleared by ready", {31'd0, arg_b_vld}, 32'd0);
        core_pulse(1, 0, 0, 8'h00);
        core_idle = 1;
        axi_rd(6'h00);                       // R5 done set
        axi_rd(6'h00);                       // R5 cleared by previous read
        // R4 auto restart
        axi_wr(6'h00, 32'h81, 4'h1, 2);
        core_pulse(0, 1, 0, 8'h00);
        core_pulse(1, 0, 0, 8'h00);
        check("R4 restarted", {31'd0, core_start}, 32'd1);
        core_pulse(1, 1, 0, 8'h00);          // R3 set wins over clear
        check("R3 set wins", {31'd0, core_start}, 32'd1);
        axi_wr(6'h00, 32'h0, 4'h1, 0);       // R2 write 0 keeps start, clears auto
        check("R2 zero write keeps start", {31'd0, core_start}, 32'd1);
        core_pulse(0, 1, 0, 8'h00);
        core_pulse(1, 0, 0, 8'h00);
        check("R4 no restart when off", {31'd0, core_start}, 32'd0);
        axi_rd(6'h00);
        // R8 result capture
        core_pulse(0, 0, 1, 8'hA5);
        axi_rd(6'h2C);
        axi_rd(6'h28);
        axi_rd(6'h2C);
        axi_wr(6'h28, 32'hFF, 4'hF, 0);
        axi_wr(6'h2C, 32'h1, 4'hF, 0);
        axi_rd(6'h28);
        axi_rd(6'h2C);
        repeat (3) @(negedge clk);
        check("R10 no read left pending", exp_q.size(), 32'd0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R10 actual=hung expected=complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule